// File: doc/BRIEF.md
# Configurable Edge-Triggered Interrupt Controller

This block watches a group of asynchronous external event lines and converts selected edges on them into latched pending flags and one interrupt request. Every line is brought into the clock domain through a synchronizer chain. The block then compares the line's synchronized level with its level one clock earlier to find edges. Each line has its own rising-edge enable, falling-edge enable, software trigger, rising pending flag, falling pending flag and interrupt mask bit.

Software configures and services the block through a simple word-indexed register bus. The write is single-cycle and the read path is combinational. Software enables the edges it cares about, unmasks lines, and answers the interrupt by reading the pending registers. It then clears the flags it has handled by writing ones to them.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0, so no edge is detected until an enable is written.
- R2: A rising edge on line n sets bit n of the rising pending register (index 3) when bit n of the rising enable register (index 0) is 1. The bit is visible after the third rising clock edge after the input changes.
- R3: A falling edge on line n sets bit n of the falling pending register (index 4) when bit n of the falling enable register (index 1) is 1. The latency is the same as in R2.
- R4: An edge on a line whose matching enable bit is 0 leaves both pending registers unchanged.
- R5: When both enables of a line are 1, a rising edge and a later falling edge each set their own pending bit.
- R6: Writing 1 to bit n of the software trigger register (index 2) sets bit n of both pending registers one cycle later. The trigger bit then clears itself and reads back 0.
- R7: The pending registers are write-1-to-clear. A 0 in the written data leaves that bit unchanged.
- R8: If a set condition and a clear write reach the same pending bit in the same cycle, the bit ends up set.
- R9: A rising edge that is evaluated in the same cycle as a bus write to the rising enable register is dropped. A falling edge that is evaluated in the same cycle as a write to the falling enable register is also dropped. In both cases the pending bit stays 0.
- R10: Bits above the implemented line count read 0 and ignore writes. Register indices 6 and 7 read 0 and ignore writes.
- R11: `irq` is 1 exactly when some line has its mask bit (register index 5) set together with either of its pending bits.
- R12: The register indices are: 0 rising enable, 1 falling enable, 2 software trigger, 3 rising pending, 4 falling pending, 5 interrupt mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lines_async | input | NUM_LINES | Asynchronous event lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The lines are driven with single rising edges, single falling edges and round trips from low to high and back. This tells apart the enable-off case, the one-direction cases and the both-edges case. The software trigger is fired alone and back to back with a clear write, which separates the plain set path from set-over-clear priority. Edges are also timed to land exactly on writes to the enable registers, for both directions, to show that they are dropped. Out-of-range bits and unused indices are written with all ones to show that they stay at 0. A behavioural reference model follows every cycle and checks each readback and `irq` against it.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      REG_RISE_EN   = 3'd0,
      REG_FALL_EN   = 3'd1,
      REG_SWTRIG    = 3'd2,
      REG_RISE_PEND = 3'd3,
      REG_FALL_PEND = 3'd4,
      REG_MASK      = 3'd5
   } reg_idx_e;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
   parameter int unsigned W      = 17,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/eirq_edge.sv
module eirq_edge #(
   parameter int unsigned W = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] level,
   output logic [W-1:0] rise_hit,
   output logic [W-1:0] fall_hit
);
   logic [W-1:0] level_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_d <= '0;
      else        level_d <= level;
   end

   assign rise_hit = level & ~level_d;
   assign fall_hit = ~level & level_d;
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
   import eirq_pkg::*;
#(
   parameter int unsigned W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [W-1:0]      wdata,
   input  logic [W-1:0]      rise_hit,
   input  logic [W-1:0]      fall_hit,
   output logic [W-1:0]      rise_en,
   output logic [W-1:0]      fall_en,
   output logic [W-1:0]      swtrig,
   output logic [W-1:0]      rise_pend,
   output logic [W-1:0]      fall_pend,
   output logic [W-1:0]      mask
);
   logic          wr_re, wr_fe, wr_sw, wr_rp, wr_fp, wr_mk;
   logic [W-1:0]  rise_set, fall_set, rise_clr, fall_clr;

   assign wr_re = wr && (addr == REG_RISE_EN);
   assign wr_fe = wr && (addr == REG_FALL_EN);
   assign wr_sw = wr && (addr == REG_SWTRIG);
   assign wr_rp = wr && (addr == REG_RISE_PEND);
   assign wr_fp = wr && (addr == REG_FALL_PEND);
   assign wr_mk = wr && (addr == REG_MASK);

   // an edge meeting a write to its own enable register is discarded
   assign rise_set = (rise_hit & rise_en & {W{~wr_re}}) | swtrig;
   assign fall_set = (fall_hit & fall_en & {W{~wr_fe}}) | swtrig;
   assign rise_clr = wr_rp ? wdata : '0;
   assign fall_clr = wr_fp ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_en   <= '0;
         fall_en   <= '0;
         swtrig    <= '0;
         rise_pend <= '0;
         fall_pend <= '0;
         mask      <= '0;
      end else begin
         if (wr_re) rise_en <= wdata;
         if (wr_fe) fall_en <= wdata;
         if (wr_mk) mask    <= wdata;
         swtrig    <= wr_sw ? wdata : '0;
         rise_pend <= (rise_pend & ~rise_clr) | rise_set;
         fall_pend <= (fall_pend & ~fall_clr) | fall_set;
      end
   end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
   import eirq_pkg::*;
#(
   parameter int unsigned NUM_LINES   = 17,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lines_async,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic                 irq
);
   localparam int unsigned NL = NUM_LINES;

   if (NL < 1 || NL > DATA_W) begin : g_bad_lines
      $error("NUM_LINES must lie in 1..DATA_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NL-1:0] lines_sync, rise_hit, fall_hit;
   logic [NL-1:0] rise_en, fall_en, swtrig, rise_pend, fall_pend, mask;
   logic [NL-1:0] rd_sel;

   eirq_sync #(.W(NL), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(lines_async), .q(lines_sync)
   );

   eirq_edge #(.W(NL)) u_edge (
      .clk(clk), .rst_n(rst_n), .level(lines_sync),
      .rise_hit(rise_hit), .fall_hit(fall_hit)
   );

   eirq_regs #(.W(NL)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata[NL-1:0]), .rise_hit(rise_hit), .fall_hit(fall_hit),
      .rise_en(rise_en), .fall_en(fall_en), .swtrig(swtrig),
      .rise_pend(rise_pend), .fall_pend(fall_pend), .mask(mask)
   );

   always_comb begin
      case (bus_addr)
         REG_RISE_EN:   rd_sel = rise_en;
         REG_FALL_EN:   rd_sel = fall_en;
         REG_SWTRIG:    rd_sel = swtrig;
         REG_RISE_PEND: rd_sel = rise_pend;
         REG_FALL_PEND: rd_sel = fall_pend;
         REG_MASK:      rd_sel = mask;
         default:       rd_sel = '0;
      endcase
      bus_rdata            = '0;
      bus_rdata[NL-1:0]    = rd_sel;
   end

   assign irq = |(mask & (rise_pend | fall_pend));
endmodule

// File: rtl/eirq_checker.sv
module eirq_checker
   import eirq_pkg::*;
#(
   parameter int unsigned NL = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq,
   input logic [NL-1:0]     rise_en,
   input logic [NL-1:0]     fall_en,
   input logic [NL-1:0]     swtrig,
   input logic [NL-1:0]     rise_pend,
   input logic [NL-1:0]     fall_pend,
   input logic [NL-1:0]     mask
);
   logic wr_sw_c, wr_rp_c, wr_fp_c;
   assign wr_sw_c = bus_wr && (bus_addr == REG_SWTRIG);
   assign wr_rp_c = bus_wr && (bus_addr == REG_RISE_PEND);
   assign wr_fp_c = bus_wr && (bus_addr == REG_FALL_PEND);

   p_swtrig_selfclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_sw_c) |=> (swtrig == '0));

   p_swtrig_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (swtrig != '0) |=> (((rise_pend & fall_pend) & $past(swtrig)) == $past(swtrig)));

   p_rpend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_rp_c) |=> ((rise_pend & $past(rise_pend)) == $past(rise_pend)));

   p_fpend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_fp_c) |=> ((fall_pend & $past(fall_pend)) == $past(fall_pend)));

   p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((rise_pend & ~$past(rise_pend) & ~($past(rise_en) | $past(swtrig))) == '0));

   p_fall_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((fall_pend & ~$past(fall_pend) & ~($past(fall_en) | $past(swtrig))) == '0));

   p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata >> NL) == '0);

   p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((mask & (rise_pend | fall_pend)) != '0));
endmodule

bind edge_irq_ctrl eirq_checker #(.NL(NUM_LINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_rdata(bus_rdata), .irq(irq), .rise_en(rise_en), .fall_en(fall_en),
   .swtrig(swtrig), .rise_pend(rise_pend), .fall_pend(fall_pend), .mask(mask)
);

// File: tb/tb_edge_irq_ctrl.sv
module tb_edge_irq_ctrl;
   localparam int NL = 17;
   localparam logic [NL-1:0] ALL = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] lines = '0;
   logic          bus_wr = 1'b0;
   logic [2:0]    bus_addr = 3'd0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   edge_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .lines_async(lines), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // behavioural reference: a history queue of sampled inputs plus register images
   logic [NL-1:0] hist[$];
   logic [NL-1:0] m_re, m_fe, m_sw, m_rp, m_fp, m_mk;

   function automatic logic [31:0] m_read(logic [2:0] a);
      case (a)
         3'd0: return 32'(m_re);
         3'd1: return 32'(m_fe);
         3'd2: return 32'(m_sw);
         3'd3: return 32'(m_rp);
         3'd4: return 32'(m_fp);
         3'd5: return 32'(m_mk);
         default: return 32'd0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist = '{NL'(0), NL'(0), NL'(0)};
         {m_re, m_fe, m_sw, m_rp, m_fp, m_mk} = '0;
      end else begin
         logic [NL-1:0] now_l, was_l, up, dn, wd, n_rp, n_fp;
         now_l = hist[1];
         was_l = hist[2];
         up = now_l & ~was_l;
         dn = was_l & ~now_l;
         wd = bus_wdata[NL-1:0];
         n_rp = m_rp | m_sw;
         n_fp = m_fp | m_sw;
         if (!(bus_wr && bus_addr == 3'd0)) n_rp = n_rp | (up & m_re);
         if (!(bus_wr && bus_addr == 3'd1)) n_fp = n_fp | (dn & m_fe);
         if (bus_wr && bus_addr == 3'd3) n_rp = n_rp & ~(wd & ~(m_sw | (up & m_re)));
         if (bus_wr && bus_addr == 3'd4) n_fp = n_fp & ~(wd & ~(m_sw | (dn & m_fe)));
         m_rp = n_rp;
         m_fp = n_fp;
         m_sw = (bus_wr && bus_addr == 3'd2) ? wd : '0;
         if (bus_wr && bus_addr == 3'd0) m_re = wd;
         if (bus_wr && bus_addr == 3'd1) m_fe = wd;
         if (bus_wr && bus_addr == 3'd5) m_mk = wd;
         hist.push_front(lines);
         void'(hist.pop_back());
      end
   end

   // every-cycle comparison, sampled 2 ns after the active edge
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         chk("R12 per-cycle readback", bus_rdata, m_read(bus_addr));
         chk("R11 per-cycle irq", 32'(irq), 32'(|(m_mk & (m_rp | m_fp))));
      end
   end

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
   endtask

   task automatic idle(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bus_wr = 1'b0;
      end
   endtask

   task automatic expect_reg(string tag, logic [2:0] a, logic [31:0] exp);
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = a;
      @(posedge clk); #2;
      chk(tag, bus_rdata, exp);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1'b1;
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int a = 0; a < 6; a++) expect_reg("R1 reset value", 3'(a), 32'd0);
      chk("R1 irq after reset", 32'(irq), 32'd0);

      // R2 / R4: rising enable on lines 0 and 2, edges on 0,1,2
      wr(3'd0, 32'h5); idle();
      lines[2:0] = 3'b111;
      idle(4);
      expect_reg("R2 rising pend", 3'd3, 32'h5);
      expect_reg("R4 no falling pend", 3'd4, 32'h0);

      // R3 / R4: falling enable on line 1, all three fall
      wr(3'd1, 32'h2); idle();
      lines[2:0] = 3'b000;
      idle(4);
      expect_reg("R3 falling pend", 3'd4, 32'h2);
      expect_reg("R4 rising pend unchanged", 3'd3, 32'h5);

      // R11 mask gating
      chk("R11 irq masked off", 32'(irq), 32'd0);
      wr(3'd5, 32'h4); idle();
      @(posedge clk); #2; chk("R11 irq via line 2", 32'(irq), 32'd1);
      wr(3'd5, 32'h8); idle();
      @(posedge clk); #2; chk("R11 irq no pending under mask", 32'(irq), 32'd0);

      // R7 write-1-to-clear
      wr(3'd3, 32'h0); idle();
      expect_reg("R7 zero write keeps", 3'd3, 32'h5);
      wr(3'd3, 32'h1); idle();
      expect_reg("R7 one write clears", 3'd3, 32'h4);
      wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'hFFFF_FFFF); idle();

      // R5 both edges on line 3
      wr(3'd0, 32'h8); wr(3'd1, 32'h8); idle();
      lines[3] = 1'b1; idle(4);
      expect_reg("R5 rise on dual line", 3'd3, 32'h8);
      lines[3] = 1'b0; idle(4);
      expect_reg("R5 fall on dual line", 3'd4, 32'h8);
      chk("R11 irq line 3 masked in", 32'(irq), 32'd1);

      // R6 software trigger
      wr(3'd2, 32'h10); idle(2);
      expect_reg("R6 swtrig self-clears", 3'd2, 32'h0);
      expect_reg("R6 sw sets rising", 3'd3, 32'h18);
      expect_reg("R6 sw sets falling", 3'd4, 32'h18);

      // R8 set beats simultaneous clear
      wr(3'd2, 32'h20); wr(3'd3, 32'h20); idle();
      expect_reg("R8 set wins over clear", 3'd3, 32'h38);
      wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'hFFFF_FFFF); idle();

      // R9 edge coinciding with enable write is dropped
      wr(3'd0, 32'h40); wr(3'd1, 32'h40); idle();
      @(negedge clk); lines[6] = 1'b1;
      @(negedge clk);
      wr(3'd0, 32'h40); idle(3);
      expect_reg("R9 rising edge dropped", 3'd3, 32'h0);
      @(negedge clk); lines[6] = 1'b0;
      @(negedge clk);
      wr(3'd1, 32'h40); idle(3);
      expect_reg("R9 falling edge dropped", 3'd4, 32'h0);

      // R10 unimplemented bits and indices
      wr(3'd5, 32'hFFFF_FFFF); idle();
      expect_reg("R10 upper bits read zero", 3'd5, 32'h1_FFFF);
      wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF); idle();
      expect_reg("R10 index 6 reads zero", 3'd6, 32'h0);
      expect_reg("R10 index 7 reads zero", 3'd7, 32'h0);
      expect_reg("R10 enables untouched", 3'd0, 32'h40);

      idle(2);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule